// File: doc/BRIEF.md
# Configuration Power-Up Start Sequencer

This block governs the phase between power-up (or a reprogram request) and the start of bitstream loading. While the active-low program request is asserted, it keeps sweeping the configuration memory with clear strobes, one memory frame per clock. When the request is withdrawn, it runs one more complete sweep from the first frame and then stops pulling the shared open-drain init line low. It then waits for as long as any other device, or an outside agent, keeps that line low.

When the line is seen high, the mode-select inputs are latched. A device set up as chain master then counts out a settling interval, so that every slave further down the chain has also seen the line go high. After that interval the block raises its ready-to-configure output. A slave raises ready one clock after the capture.

A new program request at any point abandons the current phase and restarts clearing from frame zero. The open-drain line is modelled as two plain signals: a pull-low enable that the block drives, and the sensed wired level of the line. All pins are control pins with no data stream, so there is no handshake.

Top module: `cfg_start_seq`

## Requirements
- R1: During reset and in the first cycle after it, clr_strobe is 1 with clr_frame 0, init_pull_low is 1, cfg_ready is 0 and mode_q is 0. The block leaves reset in the final clear pass.
- R2: While prog_n is low, clr_strobe is 1 in every cycle. clr_frame starts at 0 in the cycle after the request, steps by one each cycle and wraps from FRAMES-1 to 0.
- R3: Whenever prog_n is 0, init_pull_low is 1 in that same cycle, whatever the state.
- R4: In the cycle after prog_n is first sampled high, exactly FRAMES further strobes follow, with clr_frame 0 to FRAMES-1 in order. init_pull_low stays 1 during these strobes, and no other strobe follows them.
- R5: Once the final pass ends, init_pull_low is 0. cfg_ready stays 0 for as long as init_sense is low.
- R6: mode_sel is latched into mode_q in the first cycle of the wait in which init_sense is 1. Later changes of mode_sel leave mode_q unchanged until a new program request completes.
- R7: With is_master at 0 at capture, cfg_ready is 1 from the cycle after the capture.
- R8: With is_master at 1 at capture, cfg_ready rises SETTLE_CYC cycles later than for a slave. SETTLE_CYC = CLK_MHZ * SETTLE_US.
- R9: prog_n low in any state other than clearing gives, in the next cycle, a strobe at frame 0 with cfg_ready at 0.
- R10: Once cfg_ready is 1, it stays 1 while prog_n stays high, whatever init_sense and mode_sel do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (acts as power-up) |
| prog_n | input | 1 | Active-low program request, synchronous to clk |
| init_sense | input | 1 | Sensed wired level of the open-drain init line |
| mode_sel | input | MODE_W | Configuration mode-select inputs |
| is_master | input | 1 | 1 = chain master (adds the settling wait) |
| init_pull_low | output | 1 | 1 = pull the init line low |
| clr_strobe | output | 1 | Clear one memory frame this cycle |
| clr_frame | output | FRAME_W | Index of the frame being cleared |
| mode_q | output | MODE_W | Latched configuration mode |
| cfg_ready | output | 1 | Ready to begin loading the bitstream |

## Verification
The assertions assume that prog_n, init_sense, mode_sel and is_master are already synchronous to clk. They also assume that init_sense reads as the wired AND of this block's own pull-low and every outside driver, so the line can never read high while init_pull_low is 1. The bench builds init_sense with exactly that wired-AND expression from the block's pull-low and one outside hold-off signal. It changes every input just after a falling edge, so each input is stable through the following rising edge. Settling is tested with a short SETTLE_US so that master runs stay within the cycle budget.

// File: rtl/cfg_start_pkg.sv
package cfg_start_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR  = 3'd0,  // program held: endless clear sweeps
    ST_FINAL  = 3'd1,  // one last full sweep after release
    ST_HOLD   = 3'd2,  // init released by us, wait for the wired line
    ST_SETTLE = 3'd3,  // master-only settling interval
    ST_READY  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/cfg_clear_sweep.sv
module cfg_clear_sweep #(
  parameter int FRAMES  = 16,
  parameter int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  output logic               strobe,
  output logic [FRAME_W-1:0] frame,
  output logic               pass_done
);
  localparam logic [FRAME_W-1:0] LAST = FRAME_W'(FRAMES - 1);

  logic [FRAME_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign strobe    = run;
  assign frame     = cnt;
  assign pass_done = run && (cnt == LAST);

  // R2 / R4: frames advance one per cycle inside a pass and wrap at the end
  a_r2_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && cnt == LAST) |=> (cnt == '0));
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
  parameter int CYCLES = 62500,
  parameter int CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic count_en,
  output logic expired
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= RELOAD;
    else if (count_en && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R8: the interval shrinks by exactly one per enabled cycle
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == RELOAD));
endmodule

// File: rtl/cfg_start_seq.sv
module cfg_start_seq
  import cfg_start_pkg::*;
#(
  parameter int FRAMES    = 16,
  parameter int MODE_W    = 3,
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_US = 250,
  parameter int FRAME_W   = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_n,
  input  logic               init_sense,
  input  logic [MODE_W-1:0]  mode_sel,
  input  logic               is_master,
  output logic               init_pull_low,
  output logic               clr_strobe,
  output logic [FRAME_W-1:0] clr_frame,
  output logic [MODE_W-1:0]  mode_q,
  output logic               cfg_ready
);
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

  seq_state_t state, state_nx;
  logic clearing, restart, pass_done, capture, t_load, t_expired;

  assign clearing = (state == ST_CLEAR) || (state == ST_FINAL);
  assign restart  = prog_n ? (state == ST_CLEAR) : (state != ST_CLEAR);
  assign capture  = prog_n && (state == ST_HOLD) && init_sense;
  assign t_load   = capture && is_master;

  always_comb begin
    state_nx = state;
    if (!prog_n) begin
      state_nx = ST_CLEAR;
    end else begin
      unique case (state)
        ST_CLEAR:  state_nx = ST_FINAL;
        ST_FINAL:  if (pass_done) state_nx = ST_HOLD;
        ST_HOLD:   if (init_sense) state_nx = is_master ? ST_SETTLE : ST_READY;
        ST_SETTLE: if (t_expired) state_nx = ST_READY;
        ST_READY:  state_nx = ST_READY;
        default:   state_nx = ST_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FINAL;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (capture) mode_q <= mode_sel;
  end

  cfg_clear_sweep #(.FRAMES(FRAMES), .FRAME_W(FRAME_W)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (clearing),
    .restart   (restart),
    .strobe    (clr_strobe),
    .frame     (clr_frame),
    .pass_done (pass_done)
  );

  cfg_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .count_en (state == ST_SETTLE),
    .expired  (t_expired)
  );

  assign init_pull_low = !prog_n || clearing;
  assign cfg_ready     = (state == ST_READY);

  // R9: a program request always lands in clearing with ready low
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |=> (clr_strobe && !cfg_ready));
  // R5: the wait holds while the wired line reads low
  a_r5_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && prog_n && !init_sense) |=> (state == ST_HOLD && !cfg_ready));
  // R6: mode latch only moves on capture
  a_r6_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_HOLD) |=> $stable(mode_q));
  // R8: master keeps settling until the timer runs out
  a_r8_settle_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE && prog_n && !t_expired) |=> (state == ST_SETTLE));
  // R10: ready is sticky while program stays released
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && prog_n) |=> cfg_ready);
  // R4: the last pass ends by releasing init
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FINAL && pass_done && prog_n) |=> !init_pull_low);
endmodule

// File: tb/cfg_start_seq_test.sv
`timescale 1ns/1ps
module cfg_start_seq_test;
  localparam int F = 8;
  localparam int MW = 3;
  localparam int FW = 3;
  localparam int S = 250;          // 250 MHz * 1 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_n = 1'b1;
  logic ext_hold = 1'b0;
  logic [MW-1:0] mode_sel = '0;
  logic is_master = 1'b0;
  logic init_pull_low, clr_strobe, cfg_ready, init_sense;
  logic [FW-1:0] clr_frame;
  logic [MW-1:0] mode_q;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  assign init_sense = ~(init_pull_low | ext_hold);

  cfg_start_seq #(.FRAMES(F), .MODE_W(MW), .CLK_MHZ(250), .SETTLE_US(1)) uut (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .init_sense(init_sense),
    .mode_sel(mode_sel), .is_master(is_master), .init_pull_low(init_pull_low),
    .clr_strobe(clr_strobe), .clr_frame(clr_frame), .mode_q(mode_q),
    .cfg_ready(cfg_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // vector fields: [8] master, [7:5] mode, [4:0] cycles init is held after the pass
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 3'd5, 5'd0}, {1'b0, 3'd2, 5'd1}, {1'b1, 3'd7, 5'd3},
    {1'b0, 3'd1, 5'd20}, {1'b1, 3'd4, 5'd0}, {1'b0, 3'd6, 5'd9}
  };

  task automatic run_cycle(input logic m, input logic [MW-1:0] md, input int h);
    int first, strobes, rel_at, expn;
    logic [MW-1:0] other;
    @(negedge clk);
    prog_n = 1'b0; ext_hold = 1'b1; is_master = m; mode_sel = md;
    #1 chk("R3 pull low on request", init_pull_low, 1);
    for (int k = 1; k <= 11; k++) begin
      @(negedge clk);
      chk("R2 strobe", clr_strobe, 1);
      chk("R2 frame", clr_frame, (k - 1) % F);
      chk("R9 ready low", cfg_ready, 0);
    end
    prog_n = 1'b1;
    first = 0; strobes = 0;
    rel_at = F + h;
    for (int n = 1; n <= F + 40 + S && first == 0; n++) begin
      @(negedge clk);
      strobes += clr_strobe;
      if (n <= F) begin
        chk("R4 frame order", clr_frame, n - 1);
        chk("R4 init held", init_pull_low, 1);
      end
      if (n == F + 1) chk("R5 init released", init_pull_low, 0);
      if (ext_hold) chk("R5 no ready while held", cfg_ready, 0);
      if (cfg_ready) first = n;
      if (n == rel_at) ext_hold = 1'b0;
    end
    expn = ((rel_at > F + 1) ? rel_at : F + 1) + 1 + (m ? S : 0);
    chk(m ? "R8 master ready time" : "R7 slave ready time", first, expn);
    chk("R4 strobe count", strobes, F);
    chk("R6 mode latched", mode_q, md);
    other = ~md;
    mode_sel = other; ext_hold = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 mode ignores later input", mode_q, md);
    chk("R10 ready held", cfg_ready, 1);
    ext_hold = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pull low in reset", init_pull_low, 1);
    chk("R1 ready in reset", cfg_ready, 0);
    rst_n = 1'b1;
    #1;
    chk("R1 strobe", clr_strobe, 1);
    chk("R1 frame", clr_frame, 0);
    chk("R1 mode", mode_q, 0);
    first = 0;
    for (int n = 1; n <= F + 10 && first == 0; n++) begin
      @(negedge clk);
      if (cfg_ready) first = n;
    end
    chk("R7 ready after power-up", first, F + 1);

    for (int v = 0; v < 6; v++)
      run_cycle(VEC[v][8], VEC[v][7:5], int'(VEC[v][4:0]));

    // R9: abort during master settling
    @(negedge clk);
    prog_n = 1'b0; is_master = 1'b1;
    repeat (3) @(negedge clk);
    prog_n = 1'b1;
    repeat (F + 12) @(negedge clk);
    chk("R8 still settling", cfg_ready, 0);
    prog_n = 1'b0;
    #1 chk("R3 pull low mid-settle", init_pull_low, 1);
    @(negedge clk);
    chk("R9 strobe after abort", clr_strobe, 1);
    chk("R9 frame after abort", clr_frame, 0);
    chk("R9 ready after abort", cfg_ready, 0);
    prog_n = 1'b1;
    repeat (F + S + 5) @(negedge clk);
    chk("R8 ready after restart", cfg_ready, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule